// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of a single eight-line interrupt controller. A host reaches it through one address bit, separate write and read strobes and an 8-bit data bus. It walks the multi-step initialization sequence, decodes the operational commands that share the two addresses, and holds the state those commands set: the mask register, the base vector, the rotation offset and the mode flags. It also owns the in-service register. That register changes on acknowledges and on the eight encoded end-of-interrupt and rotation commands.

The request register and the priority resolver sit in neighbouring logic. The resolver presents its winning line on `best_valid`/`best_line`. This block then reports each acknowledge on `ack_fire`/`ack_line` and each initialization restart on `req_flush`, so the request latch can drop edge-captured bits. Read data is combinational while `bus_rd` is high. Every state change takes effect at the clock edge that samples the strobe.

Top module: `irqc_cmd_port`

## Requirements
- R1: After synchronous reset, the mask, in-service, rotation offset and base vector are zero, all mode flags are clear and `init_busy` is low.
- R2: An even-address write with data bit 4 set is the start command. It pulses `req_flush` in that cycle, clears mask, in-service, rotation offset, rotate-on-auto-EOI, special mask, read-select (back to request) and poll, and raises `init_busy`. If data bit 0 is clear it also clears auto-EOI and special nesting; if bit 0 is set those two flags keep their values.
- R3: The first odd-address write after the start command stores the base vector as data AND 0xF8. If start-command bit 1 (single) was set, the cascade step is skipped. The sequence ends (`init_busy` low) after the last step, unless start-command bit 0 asked for the extension step.
- R4: The extension step takes special nesting from data bit 4 and auto-EOI from data bit 1, then ends the sequence.
- R5: With `init_busy` low, an odd-address write loads the mask register. An odd-address read with poll clear returns the mask.
- R6: An even-address write with bit 4 clear and bit 3 set is the option command. If bit 1 is set, bit 0 selects the in-service register (1) or the request input (0) for even reads. If bit 6 is set, bit 5 becomes the special mask flag. Bit 2 arms poll.
- R7: An even-address write with bits 4 and 3 clear is the end command, with opcode in bits 7:5. Opcodes 0 and 4 clear and set rotate-on-auto-EOI. Opcode 6 sets the rotation offset to (bits 2:0 + 1) mod 8. Opcode 2 changes nothing.
- R8: Opcodes 1 and 5 clear the highest-priority in-service bit. Priority runs from line `rot` (highest) upward modulo 8. In special mask mode, masked bits are skipped. Opcode 5 then sets the offset to that line + 1 mod 8. With no eligible bit, nothing changes.
- R9: Opcodes 3 and 7 clear the in-service bit named by bits 2:0. Opcode 7 also sets the offset to that line + 1 mod 8.
- R10: An acknowledge (`cpu_ack`, or a read while poll is armed) with `best_valid` high and no write in that cycle raises `ack_fire` with `ack_line` = `best_line`. It sets that in-service bit unless auto-EOI is on. With auto-EOI and rotate-on-auto-EOI both on, it instead sets the offset to line + 1 mod 8. A poll read returns {best_valid, 0000, best_line} and disarms poll.
- R11: An even-address read with poll clear returns `req_vec`, or the in-service register when the read-select flag says so.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | Register address bit |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| req_vec | input | 8 | Request register from the request latch |
| best_valid | input | 1 | Resolver has a line to deliver |
| best_line | input | 3 | Resolver's winning line |
| cpu_ack | input | 1 | Processor acknowledge strobe |
| ack_fire | output | 1 | Acknowledge accepted this cycle |
| ack_line | output | 3 | Line being acknowledged |
| req_flush | output | 1 | Start-command pulse: drop edge-latched requests |
| mask_q | output | 8 | Mask register |
| isr_q | output | 8 | In-service register |
| rot_q | output | 3 | Rotation offset (highest-priority line) |
| base_q | output | 8 | Base vector |
| auto_eoi_q | output | 1 | Auto-EOI flag |
| sfnm_q | output | 1 | Special nesting flag |
| smm_q | output | 1 | Special mask flag |
| init_busy | output | 1 | Initialization sequence in progress |

## Verification
The hardest state to reach is a non-specific end command that must skip a bit. That needs several in-service bits set at once, a rotation offset away from zero, and special mask mode with a mask covering the bit that would otherwise win. The stimulus builds this up one step at a time. It acknowledges chosen lines through the resolver inputs, rotates the offset with an opcode-5 command, loads a mask and arms special mask mode. It then issues end commands whose expected victim is worked out by hand. A second pass re-initializes with auto-EOI so that acknowledges move the offset instead of the in-service register.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int LINES = 8;
    localparam int LW    = $clog2(LINES);
    localparam int DW    = 8;
    localparam int BASE_LSB = LW;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_EXT  = 2'd3
    } seq_e;

    typedef enum logic [2:0] {
        OP_RAE_CLR  = 3'd0,
        OP_NS_EOI   = 3'd1,
        OP_NOP      = 3'd2,
        OP_SP_EOI   = 3'd3,
        OP_RAE_SET  = 3'd4,
        OP_NS_ROT   = 3'd5,
        OP_SET_PRIO = 3'd6,
        OP_SP_ROT   = 3'd7
    } op_e;

    typedef struct packed {
        logic          valid;
        logic [LW-1:0] line;
    } pick_t;

    // First set bit, scanning upward from line rot with wrap-around.
    function automatic pick_t pick_top(input logic [LINES-1:0] bits,
                                       input logic [LW-1:0]    rot);
        pick_t r;
        logic [LW-1:0] idx;
        r = '0;
        for (int i = 0; i < LINES; i++) begin
            idx = rot + LW'(i);
            if (!r.valid && bits[idx]) begin
                r.valid = 1'b1;
                r.line  = idx;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start_cmd,
    input  logic          odd_wr,
    input  logic [DW-1:0] wdata,
    output logic          busy,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] base_q,
    output logic          sfnm_q,
    output logic          aeoi_q
);
    seq_e                   state_q;
    logic                   want_ext_q;
    logic                   single_q;
    logic [DW-BASE_LSB-1:0] base_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SEQ_IDLE;
            mask_q     <= '0;
            base_hi_q  <= '0;
            sfnm_q     <= 1'b0;
            aeoi_q     <= 1'b0;
            want_ext_q <= 1'b0;
            single_q   <= 1'b0;
        end else if (start_cmd) begin
            mask_q     <= '0;
            want_ext_q <= wdata[0];
            single_q   <= wdata[1];
            if (!wdata[0]) begin
                sfnm_q <= 1'b0;
                aeoi_q <= 1'b0;
            end
            state_q <= SEQ_BASE;
        end else if (odd_wr) begin
            case (state_q)
                SEQ_IDLE: mask_q <= wdata;
                SEQ_BASE: begin
                    base_hi_q <= wdata[DW-1:BASE_LSB];
                    if (single_q) state_q <= want_ext_q ? SEQ_EXT : SEQ_IDLE;
                    else          state_q <= SEQ_CASC;
                end
                SEQ_CASC: state_q <= want_ext_q ? SEQ_EXT : SEQ_IDLE;
                SEQ_EXT: begin
                    sfnm_q  <= wdata[4];
                    aeoi_q  <= wdata[1];
                    state_q <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy   = (state_q != SEQ_IDLE);
    assign base_q = {base_hi_q, {BASE_LSB{1'b0}}};

    // R5: a normal-operation odd write lands in the mask
    p_mask_load_r5: assert property (@(posedge clk) disable iff (rst)
        (odd_wr && !busy && !start_cmd) |=> (mask_q == $past(wdata)));

    // R2: start command opens the sequence with an empty mask
    p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
        start_cmd |=> (busy && mask_q == '0));

endmodule

// File: rtl/irqc_isr_ctl.sv
module irqc_isr_ctl
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_cmd,
    input  logic             end_cmd,
    input  logic [2:0]       op,
    input  logic [LW-1:0]    arg,
    input  logic             smm,
    input  logic [LINES-1:0] mask,
    input  logic             aeoi,
    input  logic             ack_take,
    input  logic [LW-1:0]    ack_line,
    output logic [LINES-1:0] isr_q,
    output logic [LW-1:0]    rot_q
);
    logic             rae_q;
    logic [LINES-1:0] isr_n;
    logic [LW-1:0]    rot_n;
    logic             rae_n;
    pick_t            victim;
    op_e              opc;

    assign opc    = op_e'(op);
    assign victim = pick_top(smm ? (isr_q & ~mask) : isr_q, rot_q);

    always_comb begin
        isr_n = isr_q;
        rot_n = rot_q;
        rae_n = rae_q;
        if (start_cmd) begin
            isr_n = '0;
            rot_n = '0;
            rae_n = 1'b0;
        end else if (end_cmd) begin
            case (opc)
                OP_RAE_CLR, OP_RAE_SET: rae_n = op[2];
                OP_NS_EOI, OP_NS_ROT: begin
                    if (victim.valid) begin
                        isr_n[victim.line] = 1'b0;
                        if (opc == OP_NS_ROT) rot_n = victim.line + LW'(1);
                    end
                end
                OP_SP_EOI, OP_SP_ROT: begin
                    isr_n[arg] = 1'b0;
                    if (opc == OP_SP_ROT) rot_n = arg + LW'(1);
                end
                OP_SET_PRIO: rot_n = arg + LW'(1);
                default: ;
            endcase
        end else if (ack_take) begin
            if (!aeoi)      isr_n[ack_line] = 1'b1;
            else if (rae_q) rot_n = ack_line + LW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_q <= '0;
            rot_q <= '0;
            rae_q <= 1'b0;
        end else begin
            isr_q <= isr_n;
            rot_q <= rot_n;
            rae_q <= rae_n;
        end
    end

    // R8: a non-specific end command removes exactly one bit when any exists
    p_ns_one_bit_r8: assert property (@(posedge clk) disable iff (rst)
        (end_cmd && !start_cmd && (op == 3'd1 || op == 3'd5) && victim.valid)
        |=> ($countones($past(isr_q) ^ isr_q) == 1));

    // R8: with nothing in service, a non-specific end command leaves state alone
    p_ns_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (end_cmd && !start_cmd && (op == 3'd1 || op == 3'd5) && isr_q == '0)
        |=> (isr_q == '0 && $stable(rot_q)));

    // R10: an acknowledge without auto-EOI marks the line in service
    p_ack_marks_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_take && !aeoi && !start_cmd && !end_cmd)
        |=> isr_q[$past(ack_line)]);

endmodule

// File: rtl/irqc_cmd_port.sv
module irqc_cmd_port
    import irqc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    req_vec,
    input  logic          best_valid,
    input  logic [2:0]    best_line,
    input  logic          cpu_ack,
    output logic          ack_fire,
    output logic [2:0]    ack_line,
    output logic          req_flush,
    output logic [7:0]    mask_q,
    output logic [7:0]    isr_q,
    output logic [2:0]    rot_q,
    output logic [7:0]    base_q,
    output logic          auto_eoi_q,
    output logic          sfnm_q,
    output logic          smm_q,
    output logic          init_busy
);
    logic wr_even, odd_wr, start_cmd, opt_cmd, end_cmd;
    logic rsel_q, poll_q, ack_take;

    assign wr_even   = bus_wr & ~bus_addr;
    assign odd_wr    = bus_wr & bus_addr;
    assign start_cmd = wr_even & bus_wdata[4];
    assign opt_cmd   = wr_even & ~bus_wdata[4] & bus_wdata[3];
    assign end_cmd   = wr_even & ~bus_wdata[4] & ~bus_wdata[3];
    assign ack_take  = (cpu_ack | (bus_rd & poll_q)) & best_valid & ~bus_wr;

    irqc_init_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (start_cmd),
        .odd_wr    (odd_wr),
        .wdata     (bus_wdata),
        .busy      (init_busy),
        .mask_q    (mask_q),
        .base_q    (base_q),
        .sfnm_q    (sfnm_q),
        .aeoi_q    (auto_eoi_q)
    );

    irqc_isr_ctl u_isr (
        .clk       (clk),
        .rst       (rst),
        .start_cmd (start_cmd),
        .end_cmd   (end_cmd),
        .op        (bus_wdata[7:5]),
        .arg       (bus_wdata[2:0]),
        .smm       (smm_q),
        .mask      (mask_q),
        .aeoi      (auto_eoi_q),
        .ack_take  (ack_take),
        .ack_line  (best_line),
        .isr_q     (isr_q),
        .rot_q     (rot_q)
    );

    always_ff @(posedge clk) begin
        if (rst || start_cmd) begin
            smm_q  <= 1'b0;
            rsel_q <= 1'b0;
            poll_q <= 1'b0;
        end else if (opt_cmd) begin
            if (bus_wdata[2]) poll_q <= 1'b1;
            if (bus_wdata[1]) rsel_q <= bus_wdata[0];
            if (bus_wdata[6]) smm_q  <= bus_wdata[5];
        end else if (bus_rd && poll_q) begin
            poll_q <= 1'b0;
        end
    end

    always_comb begin
        if (poll_q)        bus_rdata = {best_valid, 4'b0000, best_line};
        else if (bus_addr) bus_rdata = mask_q;
        else if (rsel_q)   bus_rdata = isr_q;
        else               bus_rdata = req_vec;
    end

    assign ack_fire  = ack_take;
    assign ack_line  = best_line;
    assign req_flush = start_cmd;

    // R10: a read while poll is armed disarms it
    p_poll_disarm_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && poll_q && !bus_wr) |=> !poll_q);

    // R2: after the start command nothing is in service and rotation is home
    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        req_flush |=> (isr_q == '0 && rot_q == '0 && !smm_q));

endmodule

// File: tb/test_irqc_cmd_port.sv
module test_irqc_cmd_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] req_vec = 8'h5C;
    logic       best_valid = 1'b0;
    logic [2:0] best_line = 3'd0;
    logic       cpu_ack = 1'b0;
    logic       ack_fire;
    logic [2:0] ack_line;
    logic       req_flush;
    logic [7:0] mask_q, isr_q, base_q;
    logic [2:0] rot_q;
    logic       auto_eoi_q, sfnm_q, smm_q, init_busy;

    always #10 clk = ~clk;

    irqc_cmd_port i_irqc_cmd_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_vec(req_vec), .best_valid(best_valid), .best_line(best_line),
        .cpu_ack(cpu_ack), .ack_fire(ack_fire), .ack_line(ack_line),
        .req_flush(req_flush), .mask_q(mask_q), .isr_q(isr_q), .rot_q(rot_q),
        .base_q(base_q), .auto_eoi_q(auto_eoi_q), .sfnm_q(sfnm_q),
        .smm_q(smm_q), .init_busy(init_busy)
    );

    typedef struct {
        int         sel;
        logic [7:0] val;
        string      req;
    } item_t;

    item_t sb[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return mask_q;
            1: return isr_q;
            2: return {5'b0, rot_q};
            3: return base_q;
            4: return {4'b0, init_busy, smm_q, sfnm_q, auto_eoi_q};
            5: return bus_rdata;
            6: return {ack_fire, 4'b0, ack_line};
            default: return {7'b0, req_flush};
        endcase
    endfunction

    // Monitor: compares every queued expectation at mid-cycle
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it  = sb.pop_front();
            got = observe(it.sel);
            n_chk++;
            if (got !== it.val) begin
                n_bad++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h",
                         it.req, it.sel, got, it.val);
            end
        end
    end

    task automatic chk(int sel, logic [7:0] val, string req);
        item_t it;
        it.sel = sel; it.val = val; it.req = req;
        sb.push_back(it);
    endtask

    task automatic put(logic w, logic r, logic a, logic [7:0] d, logic k);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; cpu_ack = k;
    endtask

    task automatic step();
        @(posedge clk); #2;
        bus_wr = 0; bus_rd = 0; cpu_ack = 0; bus_wdata = 8'h00;
    endtask

    task automatic wr(logic a, logic [7:0] d);
        put(1, 0, a, d, 0); step();
    endtask

    task automatic ack(logic [2:0] line);
        best_valid = 1; best_line = line;
        put(0, 0, 0, 8'h00, 1);
        step();
    endtask

    task automatic rd(logic a, logic [7:0] exp, string req);
        put(0, 1, a, 8'h00, 0);
        chk(5, exp, req);
        step();
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<5000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        chk(0, 8'h00, "R1 mask"); chk(1, 8'h00, "R1 isr");
        chk(2, 8'h00, "R1 rot");  chk(3, 8'h00, "R1 base");
        chk(4, 8'h00, "R1 flags");
        @(negedge clk); step();

        // cascade, extension requested
        put(1, 0, 0, 8'h11, 0); chk(7, 8'h01, "R2 flush pulse"); step();
        chk(4, 8'h08, "R2 busy");
        wr(1, 8'h2D); chk(3, 8'h28, "R3 base masked"); chk(4, 8'h08, "R3 wait cascade");
        wr(1, 8'h04); chk(4, 8'h08, "R3 wait extension");
        wr(1, 8'h12); chk(4, 8'h03, "R4 nesting+aeoi");
        // single, no extension: bit0 clear drops flags
        wr(0, 8'h12); chk(4, 8'h08, "R2 bit0 clears flags");
        wr(1, 8'h47); chk(3, 8'h40, "R3 base"); chk(4, 8'h00, "R3 single ends");

        wr(1, 8'hA5); chk(0, 8'hA5, "R5 mask load");
        rd(1, 8'hA5, "R5 mask read");

        best_valid = 1; best_line = 3;
        put(0, 0, 0, 8'h00, 1); chk(6, 8'h83, "R10 ack fire"); step();
        chk(1, 8'h08, "R10 isr set");
        ack(6); ack(1); chk(1, 8'h4A, "R10 isr accum");
        best_valid = 0; best_line = 0;

        rd(0, 8'h5C, "R11 request read");
        wr(0, 8'h0B); rd(0, 8'h4A, "R6 select isr");
        wr(0, 8'h20); chk(1, 8'h48, "R8 lowest line first");
        wr(0, 8'h68); chk(4, 8'h04, "R6 special mask on");
        wr(1, 8'h08);
        wr(0, 8'h20); chk(1, 8'h08, "R8 masked bit skipped");
        wr(0, 8'h48); chk(4, 8'h00, "R6 special mask off");
        wr(0, 8'hA0); chk(1, 8'h00, "R8 rotate clear"); chk(2, 8'h04, "R8 rotate offset");
        wr(0, 8'h20); chk(1, 8'h00, "R8 empty isr"); chk(2, 8'h04, "R8 empty keeps rot");

        ack(2); ack(5); best_valid = 0;
        chk(1, 8'h24, "R10 two in service");
        wr(0, 8'h20); chk(1, 8'h04, "R8 rotated priority");
        ack(7); best_valid = 0;
        wr(0, 8'hE7); chk(1, 8'h04, "R9 specific rotate"); chk(2, 8'h00, "R9 offset");
        wr(0, 8'h62); chk(1, 8'h00, "R9 specific clear");
        wr(0, 8'hC5); chk(2, 8'h06, "R7 set priority");
        wr(0, 8'h40); chk(2, 8'h06, "R7 nop rot"); chk(0, 8'h08, "R7 nop mask");

        // single with extension: auto-EOI
        wr(0, 8'h13); chk(0, 8'h00, "R2 mask cleared"); chk(2, 8'h00, "R2 rot cleared");
        wr(1, 8'h08); chk(4, 8'h08, "R3 single to extension");
        wr(1, 8'h02); chk(4, 8'h01, "R4 auto-EOI");
        wr(0, 8'h80);
        ack(3); best_valid = 0;
        chk(1, 8'h00, "R10 aeoi no isr"); chk(2, 8'h04, "R10 aeoi rotate");
        wr(0, 8'h00);
        ack(5); best_valid = 0;
        chk(2, 8'h04, "R7 rotate-aeoi cleared");

        wr(0, 8'h0C);
        best_valid = 1; best_line = 6;
        put(0, 1, 1, 8'h00, 0);
        chk(5, 8'h86, "R10 poll data"); chk(6, 8'h86, "R10 poll ack");
        step();
        best_valid = 0; best_line = 0;
        rd(1, 8'h00, "R10 poll disarmed");
        put(0, 0, 0, 8'h00, 1); chk(6, 8'h00, "R10 no winner"); step();

        wr(1, 8'hF0); wr(0, 8'h68); wr(0, 8'h0B); wr(0, 8'hC2);
        chk(2, 8'h03, "R7 set priority 3");
        wr(0, 8'h17);
        chk(4, 8'h09, "R2 bit0 keeps aeoi"); chk(0, 8'h00, "R2 mask");
        chk(2, 8'h00, "R2 rot");
        wr(1, 8'h20); wr(1, 8'h00);
        chk(4, 8'h00, "R4 ext clears"); chk(3, 8'h20, "R3 base");
        rd(0, 8'h5C, "R2 read-select reset");

        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule